// File: doc/BRIEF.md
# Video Window and Decimation Gate

This block sits in a camera pixel stream and decides, pixel by pixel, which samples to keep. The incoming bus carries pixel data with three qualifiers: frame-valid, line-valid and data-valid. The block forwards the bus one clock later and adds an accept strobe, plus markers for the first accepted pixel of a frame and of a line. It also pulses end-of-line and end-of-frame markers once the line or frame that produced accepted pixels has closed. A pixel or line counts only on clocks where data-valid is high, so cameras that pace their output with data-valid are handled.

Three modes are available. Area mode keeps a rectangle given by an X offset, a Y offset, a width and a height. Line mode clips each line by X offset and width only, and uses the height value to group accepted lines into pseudo frames. Stream mode ignores the geometry and keeps every qualified pixel, which suits sources whose line length or window changes from frame to frame. Horizontal and vertical decimation factors of 1, 2, 4 or 8 can be chosen separately. Settings are sampled when frame-valid rises and then held for the rest of that frame.

Top module: `vid_roi_gate`

## Requirements
- R1: While reset is asserted and after its release with idle inputs, out_keep, out_sof, out_sol, out_eol, out_eof, out_fval, out_lval and out_dval are all low.
- R2: In area mode (cfg_mode = 00) a qualified pixel with column index x and line index y is accepted only when x_off <= x < x_off + width and y_off <= y < y_off + height. Indices count from 0 at the start of each line and each frame.
- R3: The horizontal factor cfg_hsub encodes 00 = x1, 01 = x2, 10 = x4, 11 = x8. With factor N, only pixels whose distance from the X offset is a multiple of N are accepted, so the first pixel inside the offset is always kept.
- R4: The vertical factor cfg_vsub uses the same encoding. In area mode, only lines whose distance from the Y offset is a multiple of M are accepted. In line mode, only lines whose index since the frame start is a multiple of M are accepted.
- R5: The column index advances only on clocks where fval, lval and dval are all high. A clock with dval low is never accepted and does not shift the window or the decimation phase.
- R6: In line mode (cfg_mode = 01) the Y offset is ignored. After height lines that held accepted pixels have ended, an end-of-frame pulse is issued, and the next accepted pixel carries a new start-of-frame.
- R7: In stream mode (cfg_mode = 10 or 11) every pixel with fval, lval and dval high is accepted, whatever the geometry and decimation settings.
- R8: A window that extends past the real end of a line or frame is cut off there. Column and line indices restart at every new line and every new frame.
- R9: The mode, geometry and factors are taken from the cfg ports in the clock where fval rises, and held until the next rising fval. Changes made mid-frame apply from the next frame.
- R10: out_sof and out_sol are high with out_keep on the first accepted pixel of a frame (or pseudo frame) and of a line. out_eol and out_eof pulse for one clock, one clock after lval or fval falls, only for a line or frame that held an accepted pixel.
- R11: out_pix, out_fval, out_lval and out_dval are the inputs delayed by exactly one clock, and out_keep is aligned with out_pix.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | 00 area, 01 line, 10/11 stream |
| cfg_x_off | input | DIM_W | First column of the window |
| cfg_y_off | input | DIM_W | First line of the window (area mode) |
| cfg_width | input | DIM_W | Window width in columns |
| cfg_height | input | DIM_W | Window height in lines, or lines per pseudo frame in line mode |
| cfg_hsub | input | 2 | Horizontal decimation code |
| cfg_vsub | input | 2 | Vertical decimation code |
| in_fval | input | 1 | Frame valid |
| in_lval | input | 1 | Line valid |
| in_dval | input | 1 | Data valid |
| in_pix | input | PIX_W | Pixel data |
| out_fval | output | 1 | Delayed frame valid |
| out_lval | output | 1 | Delayed line valid |
| out_dval | output | 1 | Delayed data valid |
| out_pix | output | PIX_W | Delayed pixel data |
| out_keep | output | 1 | Accept strobe for out_pix |
| out_sof | output | 1 | First accepted pixel of a frame |
| out_eof | output | 1 | End of a frame that held accepted pixels |
| out_sol | output | 1 | First accepted pixel of a line |
| out_eol | output | 1 | End of a line that held accepted pixels |

## Verification
A wrong column or line counter shows up at the first accepted pixel of the next line or frame: out_keep rises on a pixel whose value does not match the one predicted from the window and phase. A stale line-started or frame-started flag shows up as a missing or spurious out_sol or out_sof on that same pixel. A wrong pseudo-frame count shows up as an end-of-frame pulse that arrives after the wrong number of lines. The bench encodes line and column into each pixel value, so any shift of one position is caught within the line where it happens.

// File: rtl/vid_roi_pkg.sv
package vid_roi_pkg;

   typedef enum logic [1:0] {
      MODE_AREA   = 2'd0,
      MODE_LINE   = 2'd1,
      MODE_STREAM = 2'd2
   } roi_mode_e;

   // decimation code to phase mask: x1 -> 000, x2 -> 001, x4 -> 011, x8 -> 111
   function automatic logic [2:0] dec_mask(input logic [1:0] code);
      logic [2:0] m;
      case (code)
         2'd0:    m = 3'b000;
         2'd1:    m = 3'b001;
         2'd2:    m = 3'b011;
         default: m = 3'b111;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/vid_roi_count.sv
module vid_roi_count #(
   parameter int DIM_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fval,
   input  logic             lval,
   input  logic             dval,
   output logic [DIM_W-1:0] xcnt,
   output logic [DIM_W-1:0] ycnt,
   output logic             frame_start,
   output logic             lval_fall,
   output logic             fval_fall
);

   logic fval_q, lval_q;

   assign frame_start = fval & ~fval_q;
   assign fval_fall   = fval_q & ~fval;
   assign lval_fall   = lval_q & ~lval;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fval_q <= 1'b0;
         lval_q <= 1'b0;
      end else begin
         fval_q <= fval;
         lval_q <= lval;
      end
   end

   // column index: counts qualified pixels only, saturates
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         xcnt <= '0;
      else if (!fval || !lval)
         xcnt <= '0;
      else if (dval && (xcnt != '1))
         xcnt <= xcnt + 1'b1;
   end

   // line index: advances at each line end inside the frame, saturates
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ycnt <= '0;
      else if (!fval)
         ycnt <= '0;
      else if (lval_fall && (ycnt != '1))
         ycnt <= ycnt + 1'b1;
   end

endmodule

// File: rtl/vid_roi_shadow.sv
module vid_roi_shadow #(
   parameter int DIM_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [1:0]       cfg_mode,
   input  logic [DIM_W-1:0] cfg_x_off,
   input  logic [DIM_W-1:0] cfg_y_off,
   input  logic [DIM_W-1:0] cfg_width,
   input  logic [DIM_W-1:0] cfg_height,
   input  logic [1:0]       cfg_hsub,
   input  logic [1:0]       cfg_vsub,
   output logic [1:0]       eff_mode,
   output logic [DIM_W-1:0] eff_x_off,
   output logic [DIM_W-1:0] eff_y_off,
   output logic [DIM_W-1:0] eff_width,
   output logic [DIM_W-1:0] eff_height,
   output logic [1:0]       eff_hsub,
   output logic [1:0]       eff_vsub
);

   localparam int SH_W = 4 * DIM_W + 6;

   logic [SH_W-1:0] live_w, held_q, eff_w;

   assign live_w = {cfg_mode, cfg_x_off, cfg_y_off, cfg_width, cfg_height, cfg_hsub, cfg_vsub};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         held_q <= '0;
      else if (load)
         held_q <= live_w;
   end

   // the frame-start clock already uses the fresh values
   assign eff_w = load ? live_w : held_q;
   assign {eff_mode, eff_x_off, eff_y_off, eff_width, eff_height, eff_hsub, eff_vsub} = eff_w;

endmodule

// File: rtl/vid_roi_axis.sv
module vid_roi_axis
   import vid_roi_pkg::*;
#(
   parameter int DIM_W = 12
) (
   input  logic [DIM_W-1:0] pos,
   input  logic [DIM_W-1:0] off,
   input  logic [DIM_W-1:0] len,
   input  logic [1:0]       sub,
   input  logic             clip,
   output logic             hit
);

   logic       in_span;
   logic [2:0] phase;

   assign in_span = (pos >= off) && ({1'b0, pos} < ({1'b0, off} + {1'b0, len}));
   // phase measured from the offset when clipping, from zero otherwise
   assign phase   = clip ? (pos[2:0] - off[2:0]) : pos[2:0];
   assign hit     = (in_span | ~clip) && ((phase & dec_mask(sub)) == 3'b000);

endmodule

// File: rtl/vid_roi_mark.sv
module vid_roi_mark #(
   parameter int DIM_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fval,
   input  logic             lval,
   input  logic             keep,
   input  logic             lval_fall,
   input  logic             fval_fall,
   input  logic             line_mode,
   input  logic [DIM_W-1:0] height,
   output logic             sof,
   output logic             sol,
   output logic             eol,
   output logic             eof
);

   logic             line_has, frame_has;
   logic [DIM_W-1:0] pf_cnt;
   logic             line_done, pf_hit, pf_end;

   assign line_done = lval_fall & line_has;
   assign pf_hit    = (({1'b0, pf_cnt} + 1'b1) == {1'b0, height});
   assign pf_end    = line_mode & line_done & pf_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         line_has <= 1'b0;
      else if (!lval)
         line_has <= 1'b0;
      else if (keep)
         line_has <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         frame_has <= 1'b0;
      else if (!fval || pf_end)
         frame_has <= 1'b0;
      else if (keep)
         frame_has <= 1'b1;
   end

   // lines with accepted pixels inside the current pseudo frame
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pf_cnt <= '0;
      else if (!fval || pf_end)
         pf_cnt <= '0;
      else if (line_mode && line_done)
         pf_cnt <= pf_cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sof <= 1'b0;
         sol <= 1'b0;
         eol <= 1'b0;
         eof <= 1'b0;
      end else begin
         sof <= keep & ~frame_has;
         sol <= keep & ~line_has;
         eol <= line_done;
         eof <= (fval_fall & frame_has) | pf_end;
      end
   end

endmodule

// File: rtl/vid_roi_gate.sv
module vid_roi_gate
   import vid_roi_pkg::*;
#(
   parameter int PIX_W = 16,
   parameter int DIM_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       cfg_mode,
   input  logic [DIM_W-1:0] cfg_x_off,
   input  logic [DIM_W-1:0] cfg_y_off,
   input  logic [DIM_W-1:0] cfg_width,
   input  logic [DIM_W-1:0] cfg_height,
   input  logic [1:0]       cfg_hsub,
   input  logic [1:0]       cfg_vsub,
   input  logic             in_fval,
   input  logic             in_lval,
   input  logic             in_dval,
   input  logic [PIX_W-1:0] in_pix,
   output logic             out_fval,
   output logic             out_lval,
   output logic             out_dval,
   output logic [PIX_W-1:0] out_pix,
   output logic             out_keep,
   output logic             out_sof,
   output logic             out_eof,
   output logic             out_sol,
   output logic             out_eol
);

   localparam int AXES  = 2;
   localparam int AX_X  = 0;
   localparam int AX_Y  = 1;

   generate
      if (PIX_W < 1) begin : g_bad_pix
         $error("vid_roi_gate: PIX_W must be at least 1");
      end
      if (DIM_W < 4 || DIM_W > 24) begin : g_bad_dim
         $error("vid_roi_gate: DIM_W must lie in 4..24");
      end
   endgenerate

   logic [DIM_W-1:0] xcnt, ycnt;
   logic             frame_start, lval_fall, fval_fall;

   vid_roi_count #(.DIM_W(DIM_W)) u_count (
      .clk         (clk),
      .rst_n       (rst_n),
      .fval        (in_fval),
      .lval        (in_lval),
      .dval        (in_dval),
      .xcnt        (xcnt),
      .ycnt        (ycnt),
      .frame_start (frame_start),
      .lval_fall   (lval_fall),
      .fval_fall   (fval_fall)
   );

   logic [1:0]       eff_mode, eff_hsub, eff_vsub;
   logic [DIM_W-1:0] eff_x_off, eff_y_off, eff_width, eff_height;

   vid_roi_shadow #(.DIM_W(DIM_W)) u_shadow (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (frame_start),
      .cfg_mode   (cfg_mode),
      .cfg_x_off  (cfg_x_off),
      .cfg_y_off  (cfg_y_off),
      .cfg_width  (cfg_width),
      .cfg_height (cfg_height),
      .cfg_hsub   (cfg_hsub),
      .cfg_vsub   (cfg_vsub),
      .eff_mode   (eff_mode),
      .eff_x_off  (eff_x_off),
      .eff_y_off  (eff_y_off),
      .eff_width  (eff_width),
      .eff_height (eff_height),
      .eff_hsub   (eff_hsub),
      .eff_vsub   (eff_vsub)
   );

   logic md_line, md_area, md_stream;

   assign md_area   = (eff_mode == MODE_AREA);
   assign md_line   = (eff_mode == MODE_LINE);
   assign md_stream = eff_mode[1];

   logic [DIM_W-1:0] ax_pos [AXES];
   logic [DIM_W-1:0] ax_off [AXES];
   logic [DIM_W-1:0] ax_len [AXES];
   logic [1:0]       ax_sub [AXES];
   logic             ax_clip[AXES];
   logic             ax_hit [AXES];

   assign ax_pos[AX_X]  = xcnt;
   assign ax_off[AX_X]  = eff_x_off;
   assign ax_len[AX_X]  = eff_width;
   assign ax_sub[AX_X]  = eff_hsub;
   assign ax_clip[AX_X] = 1'b1;
   assign ax_pos[AX_Y]  = ycnt;
   assign ax_off[AX_Y]  = eff_y_off;
   assign ax_len[AX_Y]  = eff_height;
   assign ax_sub[AX_Y]  = eff_vsub;
   assign ax_clip[AX_Y] = md_area;

   generate
      for (genvar a = 0; a < AXES; a++) begin : g_axis
         vid_roi_axis #(.DIM_W(DIM_W)) u_axis (
            .pos  (ax_pos[a]),
            .off  (ax_off[a]),
            .len  (ax_len[a]),
            .sub  (ax_sub[a]),
            .clip (ax_clip[a]),
            .hit  (ax_hit[a])
         );
      end
   endgenerate

   logic qual, keep;

   assign qual = in_fval & in_lval & in_dval;
   assign keep = qual & (md_stream | (ax_hit[AX_X] & ax_hit[AX_Y]));

   vid_roi_mark #(.DIM_W(DIM_W)) u_mark (
      .clk       (clk),
      .rst_n     (rst_n),
      .fval      (in_fval),
      .lval      (in_lval),
      .keep      (keep),
      .lval_fall (lval_fall),
      .fval_fall (fval_fall),
      .line_mode (md_line),
      .height    (eff_height),
      .sof       (out_sof),
      .sol       (out_sol),
      .eol       (out_eol),
      .eof       (out_eof)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_fval <= 1'b0;
         out_lval <= 1'b0;
         out_dval <= 1'b0;
         out_pix  <= '0;
         out_keep <= 1'b0;
      end else begin
         out_fval <= in_fval;
         out_lval <= in_lval;
         out_dval <= in_dval;
         out_pix  <= in_pix;
         out_keep <= keep;
      end
   end

endmodule

// File: rtl/vid_roi_chk.sv
module vid_roi_chk (
   input logic clk,
   input logic rst_n,
   input logic in_fval,
   input logic in_lval,
   input logic in_dval,
   input logic md_stream,
   input logic out_fval,
   input logic out_lval,
   input logic out_dval,
   input logic out_keep,
   input logic out_sof,
   input logic out_sol,
   input logic out_eol
);

   // R5
   keep_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_keep |-> (out_fval && out_lval && out_dval));

   // R7
   stream_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_fval && in_lval && in_dval && md_stream) |=> out_keep);

   // R10
   sol_with_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_sol |-> out_keep);

   // R10
   sof_opens_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_sof |-> out_sol);

   // R10
   eol_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_eol |=> !out_eol);

   // R10
   eol_no_pixel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_eol |-> !out_keep);

endmodule

bind vid_roi_gate vid_roi_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_fval   (in_fval),
   .in_lval   (in_lval),
   .in_dval   (in_dval),
   .md_stream (md_stream),
   .out_fval  (out_fval),
   .out_lval  (out_lval),
   .out_dval  (out_dval),
   .out_keep  (out_keep),
   .out_sof   (out_sof),
   .out_sol   (out_sol),
   .out_eol   (out_eol)
);

// File: tb/vid_roi_gate_test.sv
module vid_roi_gate_test;

   localparam int PW = 16;
   localparam int DW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    cfg_mode = '0;
   logic [DW-1:0] cfg_x_off = '0, cfg_y_off = '0, cfg_width = '0, cfg_height = '0;
   logic [1:0]    cfg_hsub = '0, cfg_vsub = '0;
   logic          in_fval = 1'b0, in_lval = 1'b0, in_dval = 1'b0;
   logic [PW-1:0] in_pix = '0;
   logic          out_fval, out_lval, out_dval, out_keep;
   logic          out_sof, out_eof, out_sol, out_eol;
   logic [PW-1:0] out_pix;

   always #4 clk = ~clk;

   vid_roi_gate #(.PIX_W(PW), .DIM_W(DW)) uut (
      .clk (clk), .rst_n (rst_n),
      .cfg_mode (cfg_mode), .cfg_x_off (cfg_x_off), .cfg_y_off (cfg_y_off),
      .cfg_width (cfg_width), .cfg_height (cfg_height),
      .cfg_hsub (cfg_hsub), .cfg_vsub (cfg_vsub),
      .in_fval (in_fval), .in_lval (in_lval), .in_dval (in_dval), .in_pix (in_pix),
      .out_fval (out_fval), .out_lval (out_lval), .out_dval (out_dval), .out_pix (out_pix),
      .out_keep (out_keep), .out_sof (out_sof), .out_eof (out_eof),
      .out_sol (out_sol), .out_eol (out_eol)
   );

   typedef struct {
      logic [PW-1:0] pix;
      bit            sof;
      bit            sol;
   } exp_t;

   exp_t  exp_q[$];
   exp_t  got;
   int    n_tests = 0;
   int    n_fail = 0;
   int    eol_seen = 0;
   int    eof_seen = 0;
   string cur_req = "R1";

   task automatic chk(bit ok, string req, string what, int act, int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // monitor: pop expectation for every accepted pixel
   always @(negedge clk) begin
      if (rst_n) begin
         if (out_eol) eol_seen++;
         if (out_eof) eof_seen++;
         if (out_keep) begin
            if (exp_q.size() == 0) begin
               chk(0, cur_req, "unexpected accepted pixel", int'(out_pix), -1);
            end else begin
               got = exp_q.pop_front();
               chk(out_pix == got.pix, cur_req, "pixel value", int'(out_pix), int'(got.pix));
               chk(out_sof == got.sof, cur_req, "sof marker", int'(out_sof), int'(got.sof));
               chk(out_sol == got.sol, cur_req, "sol marker", int'(out_sol), int'(got.sol));
            end
         end
      end
   end

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic set_cfg(int m, int xo, int yo, int w, int h, int hs, int vs);
      cfg_mode   = 2'(m);
      cfg_x_off  = DW'(xo);
      cfg_y_off  = DW'(yo);
      cfg_width  = DW'(w);
      cfg_height = DW'(h);
      cfg_hsub   = 2'(hs);
      cfg_vsub   = 2'(vs);
   endtask

   // driver: plays one frame and predicts the accepted pixels from the requirements
   task automatic send_frame(int nlines, int npix, bit gap, bit scramble);
      int   m, xo, yo, w, h, hdiv, vdiv, pf, exp_eol, exp_eof;
      bit   fh;
      exp_t item;
      m = int'(cfg_mode); xo = int'(cfg_x_off); yo = int'(cfg_y_off);
      w = int'(cfg_width); h = int'(cfg_height);
      hdiv = 1 << cfg_hsub; vdiv = 1 << cfg_vsub;
      pf = 0; fh = 0; exp_eol = 0; exp_eof = 0;
      eol_seen = 0; eof_seen = 0;
      in_fval = 1'b1;
      step(); step();
      for (int y = 0; y < nlines; y++) begin
         bit lh, yk;
         lh = 0;
         if (m == 1) yk = (y % vdiv) == 0;
         else        yk = (y >= yo) && (y < yo + h) && (((y - yo) % vdiv) == 0);
         for (int x = 0; x < npix; x++) begin
            bit xk, k;
            if (gap) begin
               in_lval = 1'b1; in_dval = 1'b0; in_pix = 16'hFFFF;
               step();
            end
            xk = (x >= xo) && (x < xo + w) && (((x - xo) % hdiv) == 0);
            k  = (m >= 2) ? 1'b1 : (xk && yk);
            in_lval = 1'b1; in_dval = 1'b1;
            in_pix  = {y[7:0], x[7:0]};
            if (k) begin
               item.pix = in_pix; item.sof = !fh; item.sol = !lh;
               exp_q.push_back(item);
               fh = 1; lh = 1;
            end
            step();
         end
         in_lval = 1'b0; in_dval = 1'b0;
         if (lh) begin
            exp_eol++;
            if (m == 1) begin
               pf++;
               if (pf == h) begin
                  exp_eof++; pf = 0; fh = 0;
               end
            end
         end
         if (scramble && y == 0) begin
            cfg_x_off = cfg_x_off + 1'b1;
            cfg_width = cfg_width + 3'd3;
         end
         step(); step(); step();
      end
      in_fval = 1'b0;
      if (fh) exp_eof++;
      step(); step(); step(); step();
      chk(exp_q.size() == 0, cur_req, "accepted pixels missing", exp_q.size(), 0);
      chk(eol_seen == exp_eol, cur_req, "eol pulse count", eol_seen, exp_eol);
      chk(eof_seen == exp_eof, cur_req, "eof pulse count", eof_seen, exp_eof);
      exp_q.delete();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished run");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk({out_keep, out_sof, out_sol, out_eol, out_eof, out_fval, out_lval, out_dval} == 8'd0,
          "R1", "outputs in reset", int'({out_keep, out_sof, out_sol, out_eol, out_eof}), 0);
      @(posedge clk); #1;
      rst_n = 1'b1;
      step(); step();
      @(negedge clk);
      chk({out_keep, out_sof, out_sol, out_eol, out_eof, out_fval} == 6'd0,
          "R1", "outputs after reset", int'({out_keep, out_sof, out_sol, out_eol, out_eof}), 0);

      // R11: exactly one clock of latency on the pixel bus (window empty)
      cur_req = "R11";
      set_cfg(0, 0, 0, 0, 0, 0, 0);
      @(posedge clk); #1;
      in_fval = 1'b1; in_lval = 1'b1; in_dval = 1'b1; in_pix = 16'hA5C3;
      @(negedge clk);
      chk(out_pix == 16'h0000, "R11", "pix before edge", int'(out_pix), 0);
      @(negedge clk);
      chk(out_pix == 16'hA5C3, "R11", "pix after one edge", int'(out_pix), 16'hA5C3);
      chk(out_fval && out_lval && out_dval && !out_keep, "R11", "qualifiers delayed",
          int'({out_fval, out_lval, out_dval, out_keep}), 14);
      in_fval = 1'b0; in_lval = 1'b0; in_dval = 1'b0; in_pix = '0;
      step(); step(); step();

      // R2 / R10: plain rectangle
      cur_req = "R2";
      set_cfg(0, 2, 1, 5, 3, 0, 0);
      send_frame(6, 10, 0, 0);

      // R3: horizontal factors x2, x4, x8
      cur_req = "R3";
      set_cfg(0, 1, 0, 9, 2, 1, 0);
      send_frame(3, 12, 0, 0);
      set_cfg(0, 3, 0, 20, 2, 2, 0);
      send_frame(2, 30, 0, 0);
      set_cfg(0, 5, 0, 30, 1, 3, 0);
      send_frame(2, 40, 0, 0);

      // R4: vertical factors x2, x8 with Y offset
      cur_req = "R4";
      set_cfg(0, 0, 1, 3, 7, 0, 1);
      send_frame(10, 4, 0, 0);
      set_cfg(0, 2, 2, 2, 17, 0, 3);
      send_frame(20, 5, 0, 0);

      // R5: data-valid gaps do not move the window or phase
      cur_req = "R5";
      set_cfg(0, 2, 0, 6, 3, 1, 0);
      send_frame(3, 10, 1, 0);

      // R6: line mode, Y offset ignored, pseudo frames of 3 lines
      cur_req = "R6";
      set_cfg(1, 2, 5, 4, 3, 0, 0);
      send_frame(8, 8, 0, 0);
      set_cfg(1, 1, 9, 6, 2, 1, 1);
      send_frame(9, 10, 1, 0);

      // R7: stream mode ignores geometry, two line lengths
      cur_req = "R7";
      set_cfg(2, 7, 7, 1, 1, 3, 3);
      send_frame(3, 6, 0, 0);
      set_cfg(3, 0, 0, 0, 0, 2, 1);
      send_frame(4, 9, 1, 0);

      // R8: window beyond line and frame end, then a fresh frame
      cur_req = "R8";
      set_cfg(0, 6, 2, 100, 50, 0, 0);
      send_frame(5, 10, 0, 0);
      set_cfg(0, 0, 0, 2, 2, 0, 0);
      send_frame(4, 5, 0, 0);

      // R9: settings changed mid-frame apply only from the next frame
      cur_req = "R9";
      set_cfg(0, 1, 0, 4, 4, 0, 0);
      send_frame(4, 12, 0, 1);
      send_frame(3, 12, 0, 0);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule